// File: doc/BRIEF.md
# Microoperation Register Datapath

This block is a small execution datapath. It holds seven general-purpose registers, steers two of its sources onto an A bus and a B bus, combines them in an arithmetic/logic unit, and can write the result back into one register on the next clock edge. Each cycle carries out exactly one microoperation. That microoperation is named by a 14-bit control word that the surrounding logic presents directly at the input.

Either bus can take its value from an external input instead of a register. The ALU result is always visible on the output port, whether or not a register is loaded. As a result, the same control word format covers register-to-register operations, loads from the input, and values sent out without storing them. The data width is a parameter with a default of 8 bits.

Top module: `regdp_core`

## Requirements
- R1: After reset every register R1..R7 holds zero.
- R2: The control word is split as A-source select in bits 13:11, B-source select in bits 10:8, destination select in bits 7:5 and ALU opcode in bits 4:0. For example, 14'b010_011_001_00101 leaves R2 minus R3 in R1.
- R3: A source select of 1..7 puts register R1..R7 on its bus. A source select of 0 puts `data_in` on its bus. This holds for the A bus and the B bus alike.
- R4: A destination select of 1..7 loads the ALU result into register R1..R7 at the rising clock edge, and every other register keeps its value.
- R5: A destination select of 0 loads no register.
- R6: `data_out` carries the ALU result of the current control word in every cycle, combinationally, with no register between input and output.
- R7: Arithmetic opcodes wrap modulo 2^width. They are 00000 pass A, 00001 A+1, 00010 A+B, 00101 A-B and 00110 A-1.
- R8: Bitwise opcodes are 01000 A AND B, 01010 A OR B, 01100 A XOR B and 01110 NOT A.
- R9: Opcode 10000 shifts A right by one bit and opcode 11000 shifts A left by one bit. Both insert a zero.
- R10: Any opcode not listed in R7 to R9 produces zero.
- R11: An XOR with the same register selected as A, B and destination clears that register.
- R12: When a register is both a source and the destination of one word, the operation uses the value the register held before the edge. The result is written exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_word | input | 14 | Microoperation control word |
| data_in | input | DATA_W | External operand selectable on either bus |
| data_out | output | DATA_W | ALU result of the current word |

## Verification
Reading a register and writing it back can fall in the same cycle. This is the case for increment-in-place and for XOR of a register with itself.

The bench provokes both. It loads all-ones into R6 and issues R6 <- R6+1, then issues R5 <- R5 XOR R5.

In each such cycle the bench judges `data_out` against a result computed from the old value. In the following cycle it reads the register back through a pass-only word with no destination. A second increment confirms that the write happened once and not twice.

// File: rtl/regdp_pkg.sv
package regdp_pkg;

    localparam int SEL_W = 3;
    localparam int OPC_W = 5;
    localparam int CW_W  = 3 * SEL_W + OPC_W;

    // field order is behaviour: bits 13:11 A, 10:8 B, 7:5 dest, 4:0 opcode
    typedef struct packed {
        logic [SEL_W-1:0] src_a;
        logic [SEL_W-1:0] src_b;
        logic [SEL_W-1:0] dest;
        logic [OPC_W-1:0] opc;
    } ctrl_t;

    localparam logic [OPC_W-1:0] OPC_PASS = 5'b00000;
    localparam logic [OPC_W-1:0] OPC_INC  = 5'b00001;
    localparam logic [OPC_W-1:0] OPC_ADD  = 5'b00010;
    localparam logic [OPC_W-1:0] OPC_SUB  = 5'b00101;
    localparam logic [OPC_W-1:0] OPC_DEC  = 5'b00110;
    localparam logic [OPC_W-1:0] OPC_AND  = 5'b01000;
    localparam logic [OPC_W-1:0] OPC_OR   = 5'b01010;
    localparam logic [OPC_W-1:0] OPC_XOR  = 5'b01100;
    localparam logic [OPC_W-1:0] OPC_NOT  = 5'b01110;
    localparam logic [OPC_W-1:0] OPC_SHR  = 5'b10000;
    localparam logic [OPC_W-1:0] OPC_SHL  = 5'b11000;

endpackage

// File: rtl/regdp_regfile.sv
module regdp_regfile #(
    parameter int DATA_W = 8,
    parameter int NREG   = 7,
    parameter int SEL_W  = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [SEL_W-1:0]             wr_sel,
    input  logic [DATA_W-1:0]            wr_data,
    output logic [NREG-1:0][DATA_W-1:0]  rf_o
);

    typedef struct packed {
        logic [NREG-1:0][DATA_W-1:0] r;
    } rf_state_t;

    rf_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NREG; i++) begin
            if (wr_sel == SEL_W'(i + 1)) begin
                st_d.r[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rf_o = st_q.r;

    // R5
    no_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel == '0) |=> $stable(st_q));

    for (genvar g = 0; g < NREG; g++) begin : g_chk
        // R4
        load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_sel == SEL_W'(g + 1)) |=> (st_q.r[g] == $past(wr_data)));
        // R4
        hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_sel != SEL_W'(g + 1)) |=> $stable(st_q.r[g]));
    end

endmodule

// File: rtl/regdp_srcmux.sv
module regdp_srcmux #(
    parameter int DATA_W = 8,
    parameter int NREG   = 7,
    parameter int SEL_W  = 3
) (
    input  logic [SEL_W-1:0]             sel,
    input  logic [DATA_W-1:0]            ext_i,
    input  logic [NREG-1:0][DATA_W-1:0]  rf_i,
    output logic [DATA_W-1:0]            bus_o
);

    always_comb begin
        bus_o = ext_i;
        for (int i = 0; i < NREG; i++) begin
            if (sel == SEL_W'(i + 1)) begin
                bus_o = rf_i[i];
            end
        end
    end

endmodule

// File: rtl/regdp_alu.sv
module regdp_alu
    import regdp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [OPC_W-1:0]  opc,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] y_o
);

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    always_comb begin
        case (opc)
            OPC_PASS: y_o = a_i;
            OPC_INC:  y_o = a_i + ONE;
            OPC_ADD:  y_o = a_i + b_i;
            OPC_SUB:  y_o = a_i - b_i;
            OPC_DEC:  y_o = a_i - ONE;
            OPC_AND:  y_o = a_i & b_i;
            OPC_OR:   y_o = a_i | b_i;
            OPC_XOR:  y_o = a_i ^ b_i;
            OPC_NOT:  y_o = ~a_i;
            OPC_SHR:  y_o = a_i >> 1;
            OPC_SHL:  y_o = a_i << 1;
            default:  y_o = '0;
        endcase
    end

endmodule

// File: rtl/regdp_core.sv
module regdp_core
    import regdp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CW_W-1:0]   ctrl_word,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out
);

    localparam int NREG  = (1 << SEL_W) - 1;
    localparam int NBUS  = 2;

    ctrl_t                        cw;
    logic [NREG-1:0][DATA_W-1:0]  rf_w;
    logic [NBUS-1:0][SEL_W-1:0]   bus_sel;
    logic [NBUS-1:0][DATA_W-1:0]  bus_w;
    logic [DATA_W-1:0]            alu_y;

    assign cw         = ctrl_t'(ctrl_word);
    assign bus_sel[0] = cw.src_a;
    assign bus_sel[1] = cw.src_b;

    for (genvar p = 0; p < NBUS; p++) begin : g_bus
        regdp_srcmux #(
            .DATA_W (DATA_W),
            .NREG   (NREG),
            .SEL_W  (SEL_W)
        ) u_mux (
            .sel   (bus_sel[p]),
            .ext_i (data_in),
            .rf_i  (rf_w),
            .bus_o (bus_w[p])
        );
    end

    regdp_alu #(
        .DATA_W (DATA_W)
    ) u_alu (
        .opc (cw.opc),
        .a_i (bus_w[0]),
        .b_i (bus_w[1]),
        .y_o (alu_y)
    );

    regdp_regfile #(
        .DATA_W (DATA_W),
        .NREG   (NREG),
        .SEL_W  (SEL_W)
    ) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_sel  (cw.dest),
        .wr_data (alu_y),
        .rf_o    (rf_w)
    );

    assign data_out = alu_y;

    // R3
    ext_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cw.src_a == '0 && cw.opc == OPC_PASS) |-> (data_out == data_in));

    // R11
    self_xor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cw.src_a == cw.src_b && cw.opc == OPC_XOR) |-> (data_out == '0));

    // R12
    self_xor_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cw.src_a != '0 && cw.src_a == cw.src_b && cw.dest == cw.src_a
         && cw.opc == OPC_XOR) |=> (rf_w[$past(cw.dest) - 1] == '0));

endmodule

// File: tb/sim_regdp_core.sv
module sim_regdp_core;

    localparam int W = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [13:0]   ctrl_word = '0;
    logic [W-1:0]  data_in = '0;
    logic [W-1:0]  data_out;

    int n_chk = 0;
    int n_err = 0;
    logic [W-1:0] e [1:7];

    regdp_core #(.DATA_W(W)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_word (ctrl_word),
        .data_in   (data_in),
        .data_out  (data_out)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // apply one word at a falling edge, sample the combinational output 2 ns later
    task automatic run(input logic [2:0] a, input logic [2:0] b, input logic [2:0] d,
                       input logic [4:0] op, input logic [W-1:0] din, output logic [W-1:0] y);
        @(negedge clk);
        ctrl_word = {a, b, d, op};
        data_in   = din;
        #2 y = data_out;
    endtask

    task automatic read_reg(input int idx, output logic [W-1:0] y);
        run(3'(idx), 3'd0, 3'd0, 5'b00000, 8'hA5, y);
    endtask

    task automatic t_reset;
        logic [W-1:0] y;
        for (int i = 1; i <= 7; i++) begin
            read_reg(i, y);
            check("R1", y, 8'h00);
        end
        run(3'd0, 3'd0, 3'd0, 5'b00000, 8'h6E, y);
        check("R6", y, 8'h6E);
    endtask

    task automatic t_load;
        logic [W-1:0] y;
        logic [W-1:0] v [1:7];
        v[1] = 8'h3C; v[2] = 8'h5A; v[3] = 8'h17; v[4] = 8'hF0;
        v[5] = 8'h81; v[6] = 8'hFF; v[7] = 8'h09;
        for (int i = 1; i <= 7; i++) begin
            run(3'd0, 3'd0, 3'(i), 5'b00000, v[i], y);
            e[i] = v[i];
        end
        for (int i = 1; i <= 7; i++) begin
            read_reg(i, y);
            check("R4", y, e[i]);
        end
        // B bus from external input: R2 + in
        run(3'd2, 3'd0, 3'd0, 5'b00010, 8'h06, y);
        check("R3", y, 8'h60);
    endtask

    task automatic t_field;
        logic [W-1:0] y;
        @(negedge clk);
        ctrl_word = 14'b010_011_001_00101;
        data_in   = 8'h00;
        #2 y = data_out;
        check("R2", y, 8'h43);
        e[1] = 8'h43;
        read_reg(1, y);
        check("R2", y, 8'h43);
    endtask

    task automatic t_arith;
        logic [W-1:0] y;
        run(3'd4, 3'd5, 3'd0, 5'b00010, 8'h00, y);
        check("R7 add wrap", y, 8'h71);
        run(3'd3, 3'd2, 3'd0, 5'b00101, 8'h00, y);
        check("R7 sub borrow", y, 8'hBD);
        run(3'd7, 3'd0, 3'd7, 5'b00110, 8'h00, y);
        check("R7 dec", y, 8'h08);
        e[7] = 8'h08;
        read_reg(7, y);
        check("R7 dec stored", y, 8'h08);
        run(3'd0, 3'd0, 3'd0, 5'b00110, 8'h00, y);
        check("R7 dec underflow", y, 8'hFF);
        run(3'd0, 3'd0, 3'd0, 5'b00001, 8'h7F, y);
        check("R7 inc", y, 8'h80);
    endtask

    task automatic t_logic;
        logic [W-1:0] y;
        run(3'd4, 3'd2, 3'd0, 5'b01000, 8'h00, y);
        check("R8 and", y, 8'h50);
        run(3'd4, 3'd3, 3'd0, 5'b01010, 8'h00, y);
        check("R8 or", y, 8'hF7);
        run(3'd2, 3'd3, 3'd0, 5'b01100, 8'h00, y);
        check("R8 xor", y, 8'h4D);
        run(3'd5, 3'd0, 3'd0, 5'b01110, 8'h00, y);
        check("R8 not", y, 8'h7E);
    endtask

    task automatic t_shift;
        logic [W-1:0] y;
        run(3'd5, 3'd0, 3'd0, 5'b10000, 8'h00, y);
        check("R9 shr", y, 8'h40);
        run(3'd5, 3'd0, 3'd0, 5'b11000, 8'h00, y);
        check("R9 shl", y, 8'h02);
        run(3'd0, 3'd0, 3'd0, 5'b10000, 8'hFF, y);
        check("R9 shr ones", y, 8'h7F);
        run(3'd0, 3'd0, 3'd0, 5'b11000, 8'hFF, y);
        check("R9 shl ones", y, 8'hFE);
    endtask

    task automatic t_unlisted;
        logic [W-1:0] y;
        run(3'd4, 3'd5, 3'd0, 5'b00011, 8'h00, y);
        check("R10 00011", y, 8'h00);
        run(3'd4, 3'd5, 3'd0, 5'b11111, 8'h00, y);
        check("R10 11111", y, 8'h00);
        run(3'd0, 3'd0, 3'd0, 5'b00100, 8'hFF, y);
        check("R10 00100", y, 8'h00);
        run(3'd6, 3'd6, 3'd0, 5'b10001, 8'hFF, y);
        check("R10 10001", y, 8'h00);
    endtask

    task automatic t_nowrite;
        logic [W-1:0] y;
        run(3'd0, 3'd4, 3'd0, 5'b00010, 8'h33, y);
        run(3'd1, 3'd1, 3'd0, 5'b01110, 8'h00, y);
        for (int i = 1; i <= 7; i++) begin
            read_reg(i, y);
            check("R5", y, e[i]);
        end
    endtask

    task automatic t_same;
        logic [W-1:0] y;
        run(3'd6, 3'd0, 3'd6, 5'b00001, 8'h00, y);
        check("R12 inc out", y, 8'h00);
        read_reg(6, y);
        check("R12 inc stored", y, 8'h00);
        run(3'd6, 3'd0, 3'd6, 5'b00001, 8'h00, y);
        check("R12 inc again", y, 8'h01);
        read_reg(6, y);
        check("R12 single write", y, 8'h01);
        e[6] = 8'h01;
        run(3'd5, 3'd5, 3'd5, 5'b01100, 8'h00, y);
        check("R11 out", y, 8'h00);
        read_reg(5, y);
        check("R11 cleared", y, 8'h00);
        e[5] = 8'h00;
        read_reg(4, y);
        check("R4 neighbour", y, e[4]);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_load();
        t_field();
        t_arith();
        t_logic();
        t_shift();
        t_unlisted();
        t_nowrite();
        t_same();
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #4000000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule